// File: doc/BRIEF.md
# Pairwise-Matrix Recency Tracker

This block keeps the use order of the ways of one cache set. Every unordered pair of ways has one stored bit, which says which way of the pair was used more recently. With the default of four ways there are six such bits. An encoded permutation needs only five bits for the same 24 orders, but the pairwise form lets the update and the victim choice be plain per-bit logic, with no encoder and no decoder.

When a hit or a fill touches a way, the owner pulses a valid strobe together with the way index. On the next edge the touched way becomes the most recent, and the order of the other ways is kept. The index of the least-recently-used way is always on the output, so a miss can pick its victim at once. The victim is decoded straight from the registers, so a touch presented in the same cycle does not change it until the edge. A rank output gives the recency position of every way, for inspection. One instance covers one set. Tags, data and set indexing belong to the surrounding cache.

Top module: `pairwise_lru_tracker`

## Requirements
- R1: While `rst_n` is low at a rising edge, the order is loaded as way 0 newest through way 3 oldest, whatever the touch inputs are: the ranks are 0,1,2,3 for ways 0..3 and `victim_way` is 3.
- R2: One edge after a touch (`touch_valid` high), the touched way has rank 0.
- R3: At a touch, every way that was newer than the touched way moves down by one rank. Every way that was older than it keeps its rank.
- R4: `victim_way` always gives the binary index of the way whose rank is NUM_WAYS-1.
- R5: `victim_way` depends only on the stored state. A touch presented in a cycle does not change it before the next rising edge.
- R6: A cycle with `touch_valid` low leaves all ranks and `victim_way` unchanged, whatever `touch_way` holds.
- R7: Touching the way that is already newest leaves the whole order unchanged.
- R8: The ranks always form a permutation of 0..NUM_WAYS-1.
- R9: `way_rank` holds the rank of way i in bits [2i+1:2i] (WAY_W bits per way, way 0 at the bottom). So right after reset it reads 8'hE4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| touch_valid | input | 1 | High for one cycle for each hit or fill |
| touch_way | input | WAY_W | Way touched when `touch_valid` is high |
| victim_way | output | WAY_W | Index of the least-recently-used way |
| way_rank | output | NUM_WAYS*WAY_W | Per-way recency rank, 0 = newest |

## Verification
The ranks and the victim after a touch are due one rising edge after the strobe. The bench drives each touch at a falling edge and compares every output with a queue model at the following falling edge, after the model has taken the same touch. The victim is combinational from the registers, so it is also sampled 1 ns after a touch is driven, while that touch is still pending. At that point it must equal the model's victim from before the touch. Reset is checked the same way: it is applied with a touch held high on the inputs, and the outputs are checked one falling edge after a low reset edge.

// File: rtl/lru_pair_pkg.sv
// Package: shared helpers for the pairwise recency matrix.
// Assumes ways are numbered 0..n-1 and pairs (lo,hi) with lo<hi are
// packed row by row into a flat vector.
package lru_pair_pkg;

    // Number of unordered pairs among n ways.
    function automatic int pair_count(input int n);
        return (n * (n - 1)) / 2;
    endfunction

    // Flat position of pair (lo,hi), lo<hi, among n ways.
    function automatic int pair_index(input int lo, input int hi, input int n);
        return lo * n - (lo * (lo + 1)) / 2 + (hi - lo - 1);
    endfunction

endpackage

// File: rtl/lru_pair_state.sv
// Module: holds one bit per way pair; bit (lo,hi)=1 means way lo is newer
// than way hi. A touch to way k sets the bits where k is the lower index
// and clears the bits where k is the higher index.
// Assumes touch_way < NUM_WAYS whenever touch_valid is high.
module lru_pair_state #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W = $clog2(NUM_WAYS),
    localparam int PAIRS = lru_pair_pkg::pair_count(NUM_WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_valid,
    input  logic [WAY_W-1:0] touch_way,
    output logic [PAIRS-1:0] pair_q
);

    // Per-pair storage, one generated register for each unordered pair.
    for (genvar lo = 0; lo < NUM_WAYS; lo++) begin : g_lo
        for (genvar hi = lo + 1; hi < NUM_WAYS; hi++) begin : g_hi
            localparam int P = lru_pair_pkg::pair_index(lo, hi, NUM_WAYS);
            localparam logic [WAY_W-1:0] LO_W = WAY_W'(lo);
            localparam logic [WAY_W-1:0] HI_W = WAY_W'(hi);

            // Update one pair bit: reset to "lower way newer", then follow touches.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pair_q[P] <= 1'b1;
                end else if (touch_valid && touch_way == LO_W) begin
                    pair_q[P] <= 1'b1;
                end else if (touch_valid && touch_way == HI_W) begin
                    pair_q[P] <= 1'b0;
                end
            end
        end
    end

    // True when way k is newer than every other way in the given pair state.
    function automatic logic is_newest(input logic [PAIRS-1:0] st, input int k);
        logic ok;
        ok = 1'b1;
        for (int a = 0; a < NUM_WAYS; a++) begin
            for (int b = a + 1; b < NUM_WAYS; b++) begin
                if (a == k && !st[lru_pair_pkg::pair_index(a, b, NUM_WAYS)]) ok = 1'b0;
                if (b == k &&  st[lru_pair_pkg::pair_index(a, b, NUM_WAYS)]) ok = 1'b0;
            end
        end
        return ok;
    endfunction

    // R2: a touched way is newest one edge later.
    p_touch_newest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        touch_valid |=> is_newest(pair_q, int'($past(touch_way))));

    // R6: no touch, no change.
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !touch_valid |=> $stable(pair_q));

endmodule

// File: rtl/lru_pair_expand.sv
// Module: expands the packed pair bits into a full NUM_WAYS x NUM_WAYS
// "row newer than column" matrix; entry r*NUM_WAYS+c. Diagonal is 0.
// Purely combinational.
module lru_pair_expand #(
    parameter int NUM_WAYS = 4,
    localparam int PAIRS = lru_pair_pkg::pair_count(NUM_WAYS),
    localparam int CELLS = NUM_WAYS * NUM_WAYS
) (
    input  logic [PAIRS-1:0] pair_q,
    output logic [CELLS-1:0] newer
);

    // Mirror each stored pair into both halves of the matrix.
    always_comb begin
        for (int r = 0; r < NUM_WAYS; r++) begin
            for (int c = 0; c < NUM_WAYS; c++) begin
                if (r == c) begin
                    newer[r * NUM_WAYS + c] = 1'b0;
                end else if (r < c) begin
                    newer[r * NUM_WAYS + c] = pair_q[lru_pair_pkg::pair_index(r, c, NUM_WAYS)];
                end else begin
                    newer[r * NUM_WAYS + c] = ~pair_q[lru_pair_pkg::pair_index(c, r, NUM_WAYS)];
                end
            end
        end
    end

endmodule

// File: rtl/lru_victim_decode.sv
// Module: finds the least-recently-used way: its row in the matrix is all
// zero (newer than no one) and every other way's entry in its column is one.
// Assumes the matrix is a consistent total order; clk/rst_n only serve the
// assertion.
module lru_victim_decode #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W = $clog2(NUM_WAYS),
    localparam int CELLS = NUM_WAYS * NUM_WAYS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CELLS-1:0] newer,
    output logic [WAY_W-1:0] victim_way
);

    logic [NUM_WAYS-1:0] oldest_hit;

    // Per-way test: row all zero and off-diagonal column all one.
    always_comb begin
        for (int m = 0; m < NUM_WAYS; m++) begin
            oldest_hit[m] = 1'b1;
            for (int n = 0; n < NUM_WAYS; n++) begin
                if (newer[m * NUM_WAYS + n]) oldest_hit[m] = 1'b0;
                if (n != m && !newer[n * NUM_WAYS + m]) oldest_hit[m] = 1'b0;
            end
        end
    end

    // Encode the one-hot test result into a way index.
    always_comb begin
        victim_way = '0;
        for (int m = 0; m < NUM_WAYS; m++) begin
            if (oldest_hit[m]) victim_way = WAY_W'(m);
        end
    end

    // R8: a consistent order has exactly one oldest way.
    p_single_oldest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest_hit) == 1);

endmodule

// File: rtl/lru_rank_calc.sv
// Module: rank of each way = number of ways newer than it (column count).
// Output packs way i's rank at [i*WAY_W +: WAY_W]. clk/rst_n only serve
// the assertions.
module lru_rank_calc #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W = $clog2(NUM_WAYS),
    localparam int CELLS = NUM_WAYS * NUM_WAYS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CELLS-1:0]          newer,
    output logic [NUM_WAYS*WAY_W-1:0] way_rank
);

    // Column population count for every way.
    always_comb begin
        for (int m = 0; m < NUM_WAYS; m++) begin
            logic [WAY_W-1:0] cnt;
            cnt = '0;
            for (int n = 0; n < NUM_WAYS; n++) begin
                cnt = cnt + WAY_W'(newer[n * NUM_WAYS + m]);
            end
            way_rank[m * WAY_W +: WAY_W] = cnt;
        end
    end

    // R8: no two ways share a rank.
    for (genvar a = 0; a < NUM_WAYS; a++) begin : g_ra
        for (genvar b = a + 1; b < NUM_WAYS; b++) begin : g_rb
            p_rank_distinct_r8: assert property (@(posedge clk) disable iff (!rst_n)
                way_rank[a * WAY_W +: WAY_W] != way_rank[b * WAY_W +: WAY_W]);
        end
    end

endmodule

// File: rtl/pairwise_lru_tracker.sv
// Module: recency tracker for one cache set. A touch makes a way newest on
// the next edge; victim_way and way_rank are combinational from the stored
// pair bits, so they show the order before any pending touch.
// Assumes touch_way < NUM_WAYS when touch_valid is high.
module pairwise_lru_tracker #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      touch_valid,
    input  logic [WAY_W-1:0]          touch_way,
    output logic [WAY_W-1:0]          victim_way,
    output logic [NUM_WAYS*WAY_W-1:0] way_rank
);

    localparam int PAIRS = lru_pair_pkg::pair_count(NUM_WAYS);
    localparam int CELLS = NUM_WAYS * NUM_WAYS;

    logic [PAIRS-1:0] pair_q;
    logic [CELLS-1:0] newer;

    lru_pair_state #(.NUM_WAYS(NUM_WAYS)) u_state (
        .clk(clk), .rst_n(rst_n), .touch_valid(touch_valid),
        .touch_way(touch_way), .pair_q(pair_q)
    );

    lru_pair_expand #(.NUM_WAYS(NUM_WAYS)) u_expand (
        .pair_q(pair_q), .newer(newer)
    );

    lru_victim_decode #(.NUM_WAYS(NUM_WAYS)) u_victim (
        .clk(clk), .rst_n(rst_n), .newer(newer), .victim_way(victim_way)
    );

    lru_rank_calc #(.NUM_WAYS(NUM_WAYS)) u_rank (
        .clk(clk), .rst_n(rst_n), .newer(newer), .way_rank(way_rank)
    );

    // R4: the victim is the way holding the last rank.
    p_victim_oldest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        way_rank[victim_way * WAY_W +: WAY_W] == WAY_W'(NUM_WAYS - 1));

    // R1: a reset edge leaves way 0 newest and the last way as victim.
    p_reset_order_r1: assert property (@(posedge clk)
        !rst_n |=> (victim_way == WAY_W'(NUM_WAYS - 1)) && (way_rank[WAY_W-1:0] == '0));

endmodule

// File: tb/pairwise_lru_tracker_test.sv
// Bench: queue model of the recency order (front = newest), compared with
// the outputs at every falling edge.
module pairwise_lru_tracker_test;

    localparam int NW = 4;
    localparam int WW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          touch_valid = 1'b0;
    logic [WW-1:0] touch_way = '0;
    logic [WW-1:0] victim_way;
    logic [NW*WW-1:0] way_rank;

    int checks = 0;
    int failures = 0;
    int order[$];
    bit finished = 1'b0;

    pairwise_lru_tracker #(.NUM_WAYS(NW)) uut (
        .clk(clk), .rst_n(rst_n), .touch_valid(touch_valid),
        .touch_way(touch_way), .victim_way(victim_way), .way_rank(way_rank)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        order = {0, 1, 2, 3};
    endtask

    task automatic model_touch(input int w);
        foreach (order[p]) begin
            if (order[p] == w) begin
                order.delete(p);
                break;
            end
        end
        order.push_front(w);
    endtask

    task automatic compare_all(input string tag);
        for (int w = 0; w < NW; w++) begin
            int exp_rank;
            exp_rank = 0;
            foreach (order[p]) if (order[p] == w) exp_rank = p;
            check(tag, $sformatf("rank of way %0d", w), int'(way_rank[w*WW +: WW]), exp_rank);
        end
        check("R4", "victim", int'(victim_way), order[NW-1]);
    endtask

    // Drive a touch at a falling edge, probe R5, then compare after the edge.
    task automatic step(input bit v, input int w, input string tag);
        touch_valid = v;
        touch_way = WW'(w);
        #1;
        check("R5", "victim while touch pending", int'(victim_way), order[NW-1]);
        @(posedge clk);
        if (v) model_touch(w);
        @(negedge clk);
        touch_valid = 1'b0;
        compare_all(tag);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        model_reset();
        touch_valid = 1'b1;
        touch_way = 2'd2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_all("R1");
        check("R9", "packed rank vector", int'(way_rank), 8'hE4);
        touch_valid = 1'b0;
        rst_n = 1'b1;

        step(1'b1, 0, "R7");
        step(1'b0, 3, "R6");
        step(1'b1, 3, "R2");
        step(1'b1, 1, "R3");
        step(1'b0, 2, "R6");
        step(1'b1, 2, "R2");
        step(1'b1, 2, "R7");
        step(1'b1, 0, "R3");

        for (int i = 0; i < 400; i++) begin
            bit v;
            v = ($urandom_range(3, 0) != 0);
            step(v, int'($urandom_range(3, 0)), v ? "R3" : "R6");
        end

        // Reset in the middle of traffic, with a touch held on the inputs.
        rst_n = 1'b0;
        touch_valid = 1'b1;
        touch_way = 2'd1;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        compare_all("R1");
        check("R9", "packed rank vector", int'(way_rank), 8'hE4);
        rst_n = 1'b1;
        touch_valid = 1'b0;

        for (int i = 0; i < 100; i++) begin
            step(1'b1, int'($urandom_range(3, 0)), "R8");
        end

        finished = 1'b1;
        finish_run();
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            finish_run();
        end
    end

endmodule